// File: doc/BRIEF.md
# Hilbert-Pair First-Order PLL FM Demodulator

This block is a sampled phase-locked loop that follows an analytic (in-phase plus quadrature) input and outputs the recovered frequency-modulation message. On each input strobe it forms the imaginary part of the product of the input pair and the conjugate of its own oscillator pair. That product is proportional to the sine of the phase error and has no double-frequency term. The product is the demodulated word. The same product also steers the oscillator, so there is no loop filter and the loop is first order.

The oscillator is a wrapping phase accumulator. Each sample it advances by a fixed centre increment plus the detector word after an arithmetic right shift. A quarter-wave table turns the upper phase bits into a cosine and sine pair, using quadrant symmetry. The quadrature filter that builds the input pair, any message post-filter and any input band-pass filtering sit outside the block. The default settings target a 22.5 kHz carrier sampled at 100 kHz with 10 kHz deviation.

Top module: `hilbert_pll_demod`

## Requirements
- R1: A synchronous active-low reset clears `out_vld`, `pd_out`, `osc_i`, `osc_q` and the phase accumulator to zero, so the first sample after reset is processed at phase 0.
- R2: `out_vld` is high in exactly the clock cycle that follows a cycle with `in_vld` high (reset not asserted). Otherwise it is low.
- R3: In a cycle with `in_vld` low, the input words are ignored. `pd_out`, `osc_i`, `osc_q` and the oscillator phase all keep their values.
- R4: For a strobed sample, `pd_out` = `in_q`·C − `in_i`·S. The result is exact in full signed width (DW+OW+1 bits). C and S are the oscillator cosine and sine at the current phase, and they are presented on `osc_i` and `osc_q` in the same output cycle.
- R5: After a strobed sample, the phase becomes (phase + FCW + (detector word >>> GAIN_SHIFT)) mod 2^PHW. The shift is arithmetic. The detector word is the value of R4.
- R6: The quarter-wave amplitude for index k (0 ≤ k < N, N = 2^(LUTAW−2)) is floor(AMP·(3·u·D² − u³) / (2·D³)), with u = 2k+1, D = 2N and AMP = 2^(OW−1)−1. Every oscillator output is nonzero and has magnitude at most AMP.
- R7: Phase bits [PHW−1:PHW−2] select the quadrant q and the next LUTAW−2 bits give the index k, with mirror m = N−1−k. The sine is +A(k), +A(m), −A(k), −A(m) for q = 0..3. The cosine is +A(m), −A(k), −A(m), +A(k) for q = 0..3.
- R8: With defaults, an analytic FM input (amplitude 2000, carrier 22.5 kHz, deviation 10 kHz, fs 100 kHz) stays locked for 750 Hz and 75 Hz tones. After 200 samples, `pd_out` lies within 15 % of the peak of its ideal value 2·(f−fc)/fs·2^24.
- R9: While in use, the oscillator pair has osc_i² + osc_q² between 0.93·AMP² and AMP². This keeps the pair close to a constant-magnitude Hilbert pair.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_vld | input | 1 | Input sample strobe |
| in_i | input | DW | In-phase input word, signed |
| in_q | input | DW | Quadrature (Hilbert) input word, signed |
| out_vld | output | 1 | Outputs updated in this cycle |
| pd_out | output | DW+OW+1 | Phase-detector word (demodulated message), signed |
| osc_i | output | OW | Oscillator cosine for the sample, signed |
| osc_q | output | OW | Oscillator sine for the sample, signed |

## Verification
The first pattern uses random input words with irregular strobes. These drive the accumulator through all quadrants, so a bit-exact per-clock comparison separates errors in the detector sign, the shift and wrap, the table formula and the quadrant mapping. Idle stretches with changing inputs check that the loop state freezes. A full-scale negative input exercises the widest products, and a reset in the middle of the stream checks the restart. Two FM tones, one fast and one slow, show whether the loop holds lock and scales its output to the frequency deviation. During those tones the oscillator magnitude is also checked.

// File: rtl/hpll_pkg.sv
// Shared helpers for the Hilbert-pair PLL.
// Assumes table sizes small enough that 64-bit intermediate products fit.
package hpll_pkg;

    // Quarter-wave amplitude at midpoint index k: cubic sine fit, floored.
    function automatic int quarter_amp(input int k, input int entries, input int amp);
        longint u;
        longint d;
        longint num;
        u   = 2 * longint'(k) + 1;
        d   = 2 * longint'(entries);
        num = longint'(amp) * (3 * u * d * d - u * u * u);
        return int'(num / (2 * d * d * d));
    endfunction

endpackage

// File: rtl/hpll_sincos.sv
// Quadrature synthesizer: maps the upper phase bits to a cosine/sine pair.
// Assumes LUTAW >= 3; the table is built at elaboration from the package fit,
// with midpoint sampling so that mirrored quadrants need no correction term.
module hpll_sincos #(
    parameter int LUTAW = 10,
    parameter int OW    = 12
) (
    input  logic [LUTAW-1:0]     ph_top,
    output logic signed [OW-1:0] cos_o,
    output logic signed [OW-1:0] sin_o
);
    import hpll_pkg::*;

    localparam int QAW = LUTAW - 2;
    localparam int QN  = 1 << QAW;
    localparam int AMP = (1 << (OW - 1)) - 1;

    logic signed [OW-1:0] qtab [QN];

    // Fill the quarter table, one constant entry per index.
    generate
        for (genvar gi = 0; gi < QN; gi++) begin : g_tab
            assign qtab[gi] = OW'(quarter_amp(gi, QN, AMP));
        end
    endgenerate

    logic [1:0]           quad;
    logic [QAW-1:0]       idx;
    logic signed [OW-1:0] a_fwd;
    logic signed [OW-1:0] a_mir;

    assign quad  = ph_top[LUTAW-1 -: 2];
    assign idx   = ph_top[QAW-1:0];
    assign a_fwd = qtab[idx];
    assign a_mir = qtab[~idx];

    // Apply quadrant sign and mirroring to both outputs.
    always_comb begin
        unique case (quad)
            2'd0: begin sin_o =  a_fwd; cos_o =  a_mir; end
            2'd1: begin sin_o =  a_mir; cos_o = -a_fwd; end
            2'd2: begin sin_o = -a_fwd; cos_o = -a_mir; end
            default: begin sin_o = -a_mir; cos_o =  a_fwd; end
        endcase
    end
endmodule

// File: rtl/hpll_phase_det.sv
// Complex-product phase detector: imaginary part of input times conjugate
// oscillator, i.e. in_q*cos - in_i*sin. Purely combinational, exact width.
module hpll_phase_det #(
    parameter int DW = 12,
    parameter int OW = 12
) (
    input  logic signed [DW-1:0]    in_i,
    input  logic signed [DW-1:0]    in_q,
    input  logic signed [OW-1:0]    lo_cos,
    input  logic signed [OW-1:0]    lo_sin,
    output logic signed [DW+OW:0]   pd
);
    localparam int PW = DW + OW;

    logic signed [PW-1:0] p_qc;
    logic signed [PW-1:0] p_is;

    // Two signed products and their sign-extended difference.
    always_comb begin
        p_qc = in_q * lo_cos;
        p_is = in_i * lo_sin;
        pd   = {p_qc[PW-1], p_qc} - {p_is[PW-1], p_is};
    end
endmodule

// File: rtl/hpll_nco.sv
// Controlled oscillator phase: wraps modulo 2^PHW, advances on each strobe by
// the centre increment plus the detector word shifted right (no multiplier).
module hpll_nco #(
    parameter int PHW        = 24,
    parameter int PDW        = 25,
    parameter int FCW        = 3774874,
    parameter int GAIN_SHIFT = 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  step,
    input  logic signed [PDW-1:0] pd,
    output logic [PHW-1:0]        phase_o
);
    logic [PHW-1:0] corr;

    assign corr = PHW'(pd >>> GAIN_SHIFT);

    // Phase register: clear on reset, advance only on a strobed sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_o <= '0;
        end else if (step) begin
            phase_o <= phase_o + PHW'(FCW) + corr;
        end
    end
endmodule

// File: rtl/hilbert_pll_demod.sv
// First-order PLL FM demodulator on an analytic input pair. The detector
// word both leaves the block as the message and steers the oscillator; no
// loop filter. Outputs are registered, valid one clock after each strobe.
// Assumes the caller supplies a proper Hilbert pair on in_i/in_q.
module hilbert_pll_demod #(
    parameter int DW         = 12,
    parameter int OW         = 12,
    parameter int PHW        = 24,
    parameter int LUTAW      = 10,
    parameter int FCW        = 3774874,
    parameter int GAIN_SHIFT = 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_vld,
    input  logic signed [DW-1:0]   in_i,
    input  logic signed [DW-1:0]   in_q,
    output logic                   out_vld,
    output logic signed [DW+OW:0]  pd_out,
    output logic signed [OW-1:0]   osc_i,
    output logic signed [OW-1:0]   osc_q
);
    localparam int PDW = DW + OW + 1;

    logic [PHW-1:0]        phase;
    logic signed [OW-1:0]  cos_c;
    logic signed [OW-1:0]  sin_c;
    logic signed [PDW-1:0] pd_c;

    hpll_sincos #(.LUTAW(LUTAW), .OW(OW)) u_sc (
        .ph_top (phase[PHW-1 -: LUTAW]),
        .cos_o  (cos_c),
        .sin_o  (sin_c)
    );

    hpll_phase_det #(.DW(DW), .OW(OW)) u_pd (
        .in_i   (in_i),
        .in_q   (in_q),
        .lo_cos (cos_c),
        .lo_sin (sin_c),
        .pd     (pd_c)
    );

    hpll_nco #(.PHW(PHW), .PDW(PDW), .FCW(FCW), .GAIN_SHIFT(GAIN_SHIFT)) u_nco (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (in_vld),
        .pd      (pd_c),
        .phase_o (phase)
    );

    // Output registers: capture detector and oscillator on each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld <= 1'b0;
            pd_out  <= '0;
            osc_i   <= '0;
            osc_q   <= '0;
        end else begin
            out_vld <= in_vld;
            if (in_vld) begin
                pd_out <= pd_c;
                osc_i  <= cos_c;
                osc_q  <= sin_c;
            end
        end
    end
endmodule

// File: rtl/hpll_checker.sv
// Property checker for hilbert_pll_demod, attached by bind below.
// Observes ports and the internal phase register; drives nothing.
module hpll_checker #(
    parameter int DW  = 12,
    parameter int OW  = 12,
    parameter int PHW = 24
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  in_vld,
    input logic                  out_vld,
    input logic signed [DW+OW:0] pd_out,
    input logic signed [OW-1:0]  osc_i,
    input logic signed [OW-1:0]  osc_q,
    input logic [PHW-1:0]        phase
);
    localparam int     AMP    = (1 << (OW - 1)) - 1;
    localparam longint PD_MAX = 2 * (longint'(1) << (DW - 1)) * AMP;

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(rst_n)) |-> (!out_vld && pd_out == 0 && osc_i == 0 && osc_q == 0 && phase == 0));

    assert_valid_lag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (out_vld == $past(in_vld)));

    assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(in_vld)) |->
            ($stable(pd_out) && $stable(osc_i) && $stable(osc_q) && $stable(phase)));

    assert_pd_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> (longint'(pd_out) <= PD_MAX && longint'(pd_out) >= -PD_MAX));

    assert_osc_nonzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> (osc_i != 0 && osc_q != 0));

    assert_osc_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> (int'(osc_i) <= AMP && int'(osc_i) >= -AMP &&
                     int'(osc_q) <= AMP && int'(osc_q) >= -AMP));
endmodule

bind hilbert_pll_demod hpll_checker #(.DW(DW), .OW(OW), .PHW(PHW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_vld  (in_vld),
    .out_vld (out_vld),
    .pd_out  (pd_out),
    .osc_i   (osc_i),
    .osc_q   (osc_q),
    .phase   (phase)
);

// File: tb/sim_hilbert_pll_demod.sv
`timescale 1ns/1ps
module sim_hilbert_pll_demod;
    localparam int     DW   = 12;
    localparam int     OW   = 12;
    localparam int     PHW  = 24;
    localparam int     GS   = 1;
    localparam int     AMP  = 2047;
    localparam int     QN   = 256;
    localparam longint MASK = (longint'(1) << PHW) - 1;
    localparam real    FS   = 100000.0;
    localparam real    FC   = 22500.0;
    localparam real    FDEV = 10000.0;
    localparam longint FCW_REF = longint'(FC / FS * 16777216.0 + 0.5);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_vld = 1'b0;
    logic signed [DW-1:0] in_i = '0;
    logic signed [DW-1:0] in_q = '0;
    logic out_vld;
    logic signed [DW+OW:0] pd_out;
    logic signed [OW-1:0] osc_i;
    logic signed [OW-1:0] osc_q;

    int checks = 0;
    int failures = 0;

    // Reference model state
    longint mph = 0;
    logic   e_vld = 1'b0;
    longint e_pd = 0;
    longint e_i = 0;
    longint e_q = 0;

    always #2 clk = ~clk;

    hilbert_pll_demod #(.DW(DW), .OW(OW), .PHW(PHW), .LUTAW(10),
                        .FCW(int'(FCW_REF)), .GAIN_SHIFT(GS)) u0 (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_i(in_i), .in_q(in_q),
        .out_vld(out_vld), .pd_out(pd_out), .osc_i(osc_i), .osc_q(osc_q)
    );

    function automatic longint ref_q(input longint k);
        longint u, d;
        u = 2 * k + 1;
        d = 2 * QN;
        return (AMP * (3 * u * d * d - u * u * u)) / (2 * d * d * d);
    endfunction

    task automatic ref_sc(input longint ph, output longint c, output longint s);
        longint q, k, f, m;
        q = (ph >> 22) & 3;
        k = (ph >> 14) & (QN - 1);
        f = ref_q(k);
        m = ref_q(QN - 1 - k);
        if (q == 0)      begin s =  f; c =  m; end
        else if (q == 1) begin s =  m; c = -f; end
        else if (q == 2) begin s = -f; c = -m; end
        else             begin s = -m; c =  f; end
    endtask

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    // Compare all outputs with the model (R1 state in reset, else R2/R4..R7).
    task automatic compare_all();
        string tag;
        tag = rst_n ? "R4/R5 pd_out" : "R1 pd_out";
        check(out_vld == e_vld, rst_n ? "R2 out_vld" : "R1 out_vld", longint'(out_vld), longint'(e_vld));
        check(longint'(pd_out) == e_pd, tag, longint'(pd_out), e_pd);
        check(longint'(osc_i) == e_i, "R6/R7 osc_i", longint'(osc_i), e_i);
        check(longint'(osc_q) == e_q, "R6/R7 osc_q", longint'(osc_q), e_q);
    endtask

    // One clock: check previous results, then drive and advance the model.
    task automatic step(input bit r, input bit v, input int i, input int q);
        longint c, s;
        @(negedge clk);
        compare_all();
        rst_n  = r;
        in_vld = v;
        in_i   = DW'(i);
        in_q   = DW'(q);
        if (!r) begin
            mph = 0; e_vld = 0; e_pd = 0; e_i = 0; e_q = 0;
        end else if (v) begin
            ref_sc(mph, c, s);
            e_i = c;
            e_q = s;
            e_pd = longint'(in_q) * c - longint'(in_i) * s;
            e_vld = 1'b1;
            mph = (mph + FCW_REF + (e_pd >>> GS)) & MASK;
        end else begin
            e_vld = 1'b0;
        end
    endtask

    // FM tone: lock and scale (R8), oscillator magnitude (R9).
    task automatic run_tone(input real fm, input int nsamp, input string req);
        real th, f, ideal, prev_ideal, peak;
        int lock_bad, mag_bad;
        longint m2;
        th = 0.0; prev_ideal = 0.0; lock_bad = 0; mag_bad = 0;
        peak = 2.0 * FDEV / FS * 16777216.0;
        for (int n = 0; n < nsamp; n++) begin
            f = FC + FDEV * $cos(2.0 * 3.141592653589793 * fm * n / FS);
            ideal = 2.0 * (f - FC) / FS * 16777216.0;
            step(1'b1, 1'b1, int'(2000.0 * $cos(th)), int'(2000.0 * $sin(th)));
            if (n > 200) begin
                if ((real'(pd_out) - prev_ideal) > 0.15 * peak ||
                    (prev_ideal - real'(pd_out)) > 0.15 * peak) lock_bad++;
            end
            if (out_vld) begin
                m2 = longint'(osc_i) * osc_i + longint'(osc_q) * osc_q;
                if (m2 > longint'(AMP) * AMP || real'(m2) < 0.93 * AMP * AMP) mag_bad++;
            end
            prev_ideal = ideal;
            th = th + 2.0 * 3.141592653589793 * f / FS;
        end
        check(lock_bad == 0, req, lock_bad, 0);
        check(mag_bad == 0, "R9 magnitude", mag_bad, 0);
    endtask

    initial begin
        #(4 * 200000);
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic signed [DW+OW:0] h_pd;
        logic signed [OW-1:0]  h_i, h_q;
        // R1: reset holds everything at zero
        repeat (3) step(1'b0, 1'b1, 100, -100);
        // R1: first sample runs at phase 0 (cos = A(N-1), sin = A(0))
        step(1'b1, 1'b1, 1000, 0);
        step(1'b1, 1'b0, 0, 0);
        check(longint'(osc_i) == ref_q(QN - 1) && longint'(osc_q) == ref_q(0),
              "R1 phase zero", longint'(osc_i), ref_q(QN - 1));
        // R4/R5/R7: random words with irregular strobes
        for (int n = 0; n < 400; n++)
            step(1'b1, ($urandom % 4) != 0, int'($urandom % 4096) - 2048,
                 int'($urandom % 4096) - 2048);
        // R3: idle cycles with moving inputs leave outputs and phase alone
        step(1'b1, 1'b1, 1500, -700);
        step(1'b1, 1'b0, 33, 44);
        h_pd = pd_out; h_i = osc_i; h_q = osc_q;
        for (int n = 0; n < 5; n++) begin
            step(1'b1, 1'b0, int'($urandom % 4096) - 2048, int'($urandom % 4096) - 2048);
            check(pd_out == h_pd && osc_i == h_i && osc_q == h_q && !out_vld,
                  "R3 hold", longint'(pd_out), longint'(h_pd));
        end
        step(1'b1, 1'b1, 900, 900);  // model compare proves phase did not move
        // R4: full-scale negative corner
        for (int n = 0; n < 6; n++) step(1'b1, 1'b1, -2048, -2048);
        for (int n = 0; n < 6; n++) step(1'b1, 1'b1, 2047, -2048);
        // R1: reset in mid-stream with strobe high
        step(1'b0, 1'b1, 500, 500);
        step(1'b0, 1'b1, 500, 500);
        step(1'b1, 1'b0, 0, 0);
        check(pd_out == 0 && !out_vld && osc_i == 0, "R1 mid reset", longint'(pd_out), 0);
        // R8/R9: FM tones, each from a fresh reset
        step(1'b0, 1'b0, 0, 0);
        run_tone(750.0, 1500, "R8 lock 750Hz");
        step(1'b0, 1'b0, 0, 0);
        run_tone(75.0, 3000, "R8 lock 75Hz");
        step(1'b1, 1'b0, 0, 0);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule